// File: doc/BRIEF.md
# Eight-Channel Single-Line PCM Deserializer

This block takes eight channels of 24-bit PCM audio that share one serial data line and turns them into eight parallel words. It is clocked by the bit clock, which runs at 256 times the sample rate. A frame clock divides every 256-bit frame into two halves of 128 bit clocks. In each half, four 24-bit words arrive back to back, most significant bit first, and the last 32 bit clocks of the half are padding.

The block keeps its own bit position inside the current half and restarts it on every frame-clock transition. It routes each completed word to its channel slot. Once the last bit of the eighth channel has been taken in, it updates all eight outputs together and pulses a valid strobe for one cycle. When a half runs longer or shorter than 128 bit clocks, the block flags a frame error and aligns to the transition that revealed the fault. It does not publish a frame unless a complete first half was received before it.

Top module: `pcm8_line_rx`

## Requirements
- R1: While reset is held and on the cycle after it is released, `words_valid_o` and `frame_err_o` are 0 and `pcm_words_o` is all zero.
- R2: Data is sampled on the rising bit-clock edge. The first rising edge at which a new frame-clock level is seen carries the most significant bit of the first word of that half. The following 23 edges carry the remaining bits, most significant first.
- R3: Words received while the frame clock is 0 go to channels 0 to 3, and words received while it is 1 go to channels 4 to 7, in order of arrival. Channel k appears on `pcm_words_o[24k+23:24k]`.
- R4: Bits at positions 96 to 127 of a half have no effect on any channel word.
- R5: `words_valid_o` is high for exactly one cycle. That cycle is the one after the edge that samples bit position 95 of a frame-clock-high half.
- R6: `pcm_words_o` changes only together with a `words_valid_o` pulse and holds its value between pulses.
- R7: A frame-clock transition that ends a half shorter than 128 bit clocks raises `frame_err_o` for one cycle, on the cycle after that transition. The position count restarts at that transition, and the frame it interrupts is not published.
- R8: No strobe is given for a frame-clock-high half unless the preceding frame-clock-low half began at a transition and reached position 95 with no error in between. The first frame after reset is therefore never published, and no error is flagged before the first transition.
- R9: A half longer than 128 bit clocks also raises `frame_err_o` at the transition that ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk_i | input | 1 | Frame clock; 0 marks the first half, 1 the second |
| sdata_i | input | 1 | Serial audio data |
| pcm_words_o | output | 192 | Eight 24-bit channel words, channel k at bits 24k+23:24k |
| words_valid_o | output | 1 | One-cycle strobe when a new frame is on `pcm_words_o` |
| frame_err_o | output | 1 | One-cycle pulse on a half of the wrong length |

## Verification
A wrong position count shows up at the first strobe after the fault. That strobe arrives on the wrong cycle, or the words it carries are shifted or mixed with padding bits, so the fault is visible within one frame. A wrong slot index or a lost word shows as a mismatch in one specific channel lane. A wrong error or arming state shows as a missing or unexpected strobe or error pulse at the next frame-clock transition. The bench compares every output on every bit clock against a frame-level model, so a fault is reported on the cycle it first reaches the ports.

// File: rtl/pcm8_pkg.sv
// Package: shared defaults and the half-frame encoding for the
// single-line eight-channel deserializer.
package pcm8_pkg;
    localparam int unsigned WORD_W_DEF    = 24;
    localparam int unsigned WORDS_PER_HALF_DEF = 4;
    localparam int unsigned HALF_LEN_DEF  = 128;

    // Frame-clock level names: first half of frame and second half.
    typedef enum logic {
        HALF_A = 1'b0,
        HALF_B = 1'b1
    } half_e;
endpackage

// File: rtl/pcm8_half_timer.sv
// Module: pcm8_half_timer
// Tracks the bit position inside the current frame-clock half. It
// detects frame-clock transitions, flags halves of the wrong length and
// tells the datapath when a data bit is present and when a word ends.
// Assumes: lr_i is stable around the rising edge of clk, and the first
// data bit shares the edge at which the new level is first seen.
module pcm8_half_timer #(
    parameter  int unsigned WORD_W         = 24,
    parameter  int unsigned WORDS_PER_HALF = 4,
    parameter  int unsigned HALF_LEN       = 128,
    localparam int unsigned WIDX_W = (WORDS_PER_HALF > 1) ? $clog2(WORDS_PER_HALF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_i,
    output logic              edge_o,
    output logic              err_now_o,
    output logic              err_o,
    output logic              sample_en_o,
    output logic              word_end_o,
    output logic              half_last_o,
    output logic [WIDX_W-1:0] word_idx_o
);
    localparam int unsigned CNT_W = $clog2(HALF_LEN) + 1;
    localparam int unsigned BIT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0]  LAST_POS  = CNT_W'(HALF_LEN - 1);
    localparam logic [CNT_W-1:0]  DATA_END  = CNT_W'(WORD_W * WORDS_PER_HALF);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(WORD_W - 1);
    localparam logic [WIDX_W-1:0] WORD_LAST = WIDX_W'(WORDS_PER_HALF - 1);

    logic              lr_q;
    logic              synced_q;
    logic              err_q;
    logic [CNT_W-1:0]  pos_q,  pos_now;
    logic [BIT_W-1:0]  bit_q,  bit_now;
    logic [WIDX_W-1:0] word_q, word_now;
    logic              edge_now, in_data;

    // Next position, bit and word index; a transition restarts all three.
    always_comb begin
        edge_now = lr_i ^ lr_q;
        pos_now  = '0;
        bit_now  = '0;
        word_now = '0;
        if (!edge_now) begin
            pos_now = (pos_q == CNT_MAX) ? pos_q : pos_q + 1'b1;
            if (bit_q == BIT_LAST) begin
                bit_now  = '0;
                word_now = word_q + 1'b1;
            end else begin
                bit_now  = bit_q + 1'b1;
                word_now = word_q;
            end
        end
        in_data = (synced_q | edge_now) && (pos_now < DATA_END);
    end

    assign edge_o      = edge_now;
    assign err_now_o   = edge_now && synced_q && (pos_q != LAST_POS);
    assign err_o       = err_q;
    assign sample_en_o = in_data;
    assign word_end_o  = in_data && (bit_now == BIT_LAST);
    assign half_last_o = word_end_o && (word_now == WORD_LAST);
    assign word_idx_o  = word_now;

    // Register the counters, the sync state and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_q     <= 1'b0;
            synced_q <= 1'b0;
            err_q    <= 1'b0;
            pos_q    <= '0;
            bit_q    <= '0;
            word_q   <= '0;
        end else begin
            lr_q     <= lr_i;
            synced_q <= synced_q | edge_now;
            err_q    <= err_now_o;
            pos_q    <= pos_now;
            bit_q    <= bit_now;
            word_q   <= word_now;
        end
    end

    // R7: the cycle showing an error also shows the restarted count.
    a_r7_err_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (pos_q == '0));

    // R2: after any level change of the frame clock the count is at zero.
    a_r2_edge_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_q != $past(lr_q)) |-> (pos_q == '0));
endmodule

// File: rtl/pcm8_word_shifter.sv
// Module: pcm8_word_shifter
// Collects serial bits most significant first. word_o shows the word
// completed by the current bit, so a slot can be loaded on the very
// edge that samples its last bit.
// Assumes: sample_en is high only on data bit positions.
module pcm8_word_shifter #(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-2:0] sh_q;

    assign word_o = {sh_q, bit_i};

    // Shift in one bit per data position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (sample_en) begin
            sh_q <= word_o[WORD_W-2:0];
        end
    end
endmodule

// File: rtl/pcm8_slot_bank.sv
// Module: pcm8_slot_bank
// Holds one staging word per channel and the published output words.
// On fire_i every output is loaded from staging, and the slot written
// in that same cycle takes the incoming word directly.
// Assumes: slot is below NUM_CH whenever wr_en is high.
module pcm8_slot_bank #(
    parameter  int unsigned WORD_W = 24,
    parameter  int unsigned NUM_CH = 8,
    localparam int unsigned SLOT_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SLOT_W-1:0]        slot,
    input  logic [WORD_W-1:0]        word_i,
    input  logic                     fire_i,
    output logic [NUM_CH*WORD_W-1:0] data_o
);
    for (genvar k = 0; k < NUM_CH; k++) begin : g_slot
        logic [WORD_W-1:0] stage_q;
        logic [WORD_W-1:0] out_q;
        logic              hit;

        assign hit = wr_en && (slot == SLOT_W'(k));

        // Stage the word for this channel and publish it on fire.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= '0;
                out_q   <= '0;
            end else begin
                if (hit) begin
                    stage_q <= word_i;
                end
                if (fire_i) begin
                    out_q <= hit ? word_i : stage_q;
                end
            end
        end

        assign data_o[k*WORD_W +: WORD_W] = out_q;
    end

    // R3: the timer never addresses a slot beyond the channel count.
    a_r3_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(slot) < NUM_CH));
endmodule

// File: rtl/pcm8_line_rx.sv
// Module: pcm8_line_rx (top)
// Deserializes eight 24-bit channels from one serial line. Four words
// arrive in each frame-clock half, followed by unused padding clocks.
// Publishes all eight words with a one-cycle strobe, and only when the
// first half of the frame was received completely.
// Assumes: clk is the bit clock; frame_clk_i is low for the first half.
module pcm8_line_rx
    import pcm8_pkg::*;
#(
    parameter  int unsigned WORD_W         = WORD_W_DEF,
    parameter  int unsigned WORDS_PER_HALF = WORDS_PER_HALF_DEF,
    parameter  int unsigned HALF_LEN       = HALF_LEN_DEF,
    localparam int unsigned NUM_CH         = 2 * WORDS_PER_HALF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_clk_i,
    input  logic                     sdata_i,
    output logic [NUM_CH*WORD_W-1:0] pcm_words_o,
    output logic                     words_valid_o,
    output logic                     frame_err_o
);
    localparam int unsigned WIDX_W = (WORDS_PER_HALF > 1) ? $clog2(WORDS_PER_HALF) : 1;
    localparam int unsigned SLOT_W = $clog2(NUM_CH);

    logic              edge_now, err_now, sample_en, word_end, half_last;
    logic [WIDX_W-1:0] word_idx;
    logic [WORD_W-1:0] word;
    logic [SLOT_W-1:0] slot;
    logic              in_b, fire;
    logic              have_left_q, valid_q;

    assign in_b = (half_e'(frame_clk_i) == HALF_B);

    pcm8_half_timer #(
        .WORD_W(WORD_W), .WORDS_PER_HALF(WORDS_PER_HALF), .HALF_LEN(HALF_LEN)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .lr_i(frame_clk_i),
        .edge_o(edge_now), .err_now_o(err_now), .err_o(frame_err_o),
        .sample_en_o(sample_en), .word_end_o(word_end),
        .half_last_o(half_last), .word_idx_o(word_idx)
    );

    pcm8_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
        .bit_i(sdata_i), .word_o(word)
    );

    // Channel slot: second-half words sit above the first-half words.
    assign slot = in_b ? (SLOT_W'(WORDS_PER_HALF) + SLOT_W'(word_idx))
                       : SLOT_W'(word_idx);
    assign fire = half_last && in_b && have_left_q;

    pcm8_slot_bank #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(word_end), .slot(slot),
        .word_i(word), .fire_i(fire), .data_o(pcm_words_o)
    );

    // Arm on a complete first half; disarm on a new frame or an error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_left_q <= 1'b0;
        end else if (edge_now && (!in_b || err_now)) begin
            have_left_q <= 1'b0;
        end else if (half_last && !in_b) begin
            have_left_q <= 1'b1;
        end
    end

    // Register the frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= fire;
        end
    end

    assign words_valid_o = valid_q;

    // R5: the strobe never lasts more than one cycle.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        words_valid_o |=> !words_valid_o);

    // R5: the strobe follows a sample taken in the second half.
    a_r5_after_b_half: assert property (@(posedge clk) disable iff (!rst_n)
        words_valid_o |-> ($past(frame_clk_i) == 1'b1));

    // R6: outputs hold between strobes.
    a_r6_hold_words: assert property (@(posedge clk) disable iff (!rst_n)
        !words_valid_o |-> $stable(pcm_words_o));
endmodule

// File: tb/pcm8_line_rx_tb.sv
// Bench for pcm8_line_rx: whole frames of arithmetic patterns, halves
// of bad length, and checks of every output on every bit clock against
// a frame-level model.
module pcm8_line_rx_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_clk = 1'b0;
    logic         sdata = 1'b0;
    logic [191:0] words;
    logic         valid, err;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pcm8_line_rx u_dut (
        .clk(clk), .rst_n(rst_n), .frame_clk_i(frame_clk), .sdata_i(sdata),
        .pcm_words_o(words), .words_valid_o(valid), .frame_err_o(err)
    );

    // Frame-level model state.
    logic         m_lvl = 1'b0;
    logic         m_sync = 1'b0;
    logic         m_left = 1'b0;
    int           m_len = 0;
    logic [23:0]  cur_words [8];
    logic [191:0] exp_data = '0;
    logic [191:0] pend_data = '0;
    logic         pend_v = 1'b0;
    logic         pend_e = 1'b0;
    string        pend_tag = "R1";

    function automatic logic [23:0] pattern(input int f, input int k);
        case (f % 4)
            0: pattern = 24'h000000;
            1: pattern = 24'hFFFFFF;
            2: pattern = 24'h000001 << ((k * 3 + f) % 24);
            default: pattern = 24'(f * 32'h9E3779 + k * 32'h01F3A5) ^ 24'(k << 20);
        endcase
    endfunction

    task automatic check_outputs();
        if (pend_v) exp_data = pend_data;
        tests++;
        if (valid !== pend_v || err !== pend_e) begin
            fails++;
            $display("FAIL %s: valid/err = %b/%b, expected %b/%b",
                     pend_tag, valid, err, pend_v, pend_e);
        end
        tests++;
        if (words !== exp_data) begin
            fails++;
            $display("FAIL %s (R3/R4/R6 data): got %h expected %h",
                     pend_tag, words, exp_data);
        end
    endtask

    task automatic step(input logic lvl, input logic b, input logic ev,
                        input logic ee, input string tag);
        @(negedge clk);
        check_outputs();
        frame_clk = lvl;
        sdata     = b;
        pend_v    = ev;
        pend_e    = ee;
        pend_tag  = tag;
        if (ev) begin
            for (int k = 0; k < 8; k++) pend_data[k*24 +: 24] = cur_words[k];
        end
    endtask

    // One frame-clock half of n bits; channels from base, junk in the tail.
    task automatic send_half(input logic lvl, input int n, input int f, input string tag);
        for (int i = 0; i < n; i++) begin
            logic ev, ee, b;
            ev = 1'b0;
            ee = 1'b0;
            if (i == 0 && lvl != m_lvl) begin
                ee     = m_sync && (m_len != 128);   // R7, R9
                m_sync = 1'b1;
                m_len  = 0;
                if (ee || lvl == 1'b0) m_left = 1'b0;
            end
            m_lvl = lvl;
            if (m_sync && m_len < 255) m_len++;
            if (m_sync && i == 95) begin
                if (lvl == 1'b0) m_left = 1'b1;
                else if (m_left) ev = 1'b1;        // R5, R8
            end
            if (i < 96)
                b = cur_words[(lvl ? 4 : 0) + i / 24][23 - (i % 24)];  // R2, R3
            else
                b = ((i * 5 + f) % 3) != 0;        // R4 padding junk
            step(lvl, b, ev, ee, tag);
        end
    endtask

    task automatic send_frame(input int f, input int nl, input int nr, input string tag);
        for (int k = 0; k < 8; k++) cur_words[k] = pattern(f, k);
        send_half(1'b0, nl, f, tag);
        send_half(1'b1, nr, f, tag);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) cur_words[k] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state.
        tests++;
        if (valid !== 1'b0 || err !== 1'b0 || words !== '0) begin
            fails++;
            $display("FAIL R1: valid=%b err=%b words=%h expected 0/0/0", valid, err, words);
        end
        rst_n = 1'b1;
        // R1 after release, then R8: first frame has no opening edge.
        send_frame(90, 128, 128, "R8 first frame");
        // R2 R3 R4 R5 R6: full frames over several patterns.
        for (int f = 0; f < 8; f++) send_frame(f, 128, 128, "R5 full frame");
        // R7: short first half, error at the second-half edge, no strobe.
        send_frame(11, 100, 128, "R7 short A half");
        send_frame(12, 128, 128, "R7 recovery");
        // R9: long second half; strobe still given, error at next edge.
        send_frame(13, 128, 140, "R9 long B half");
        send_frame(14, 128, 128, "R9 recovery");
        // R7 R8: second half cut before the last word.
        send_frame(15, 128, 60, "R7 short B half");
        send_frame(16, 128, 128, "R8 after short B");
        send_frame(17, 128, 128, "R6 final frame");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R6 flush");
        @(negedge clk);
        check_outputs();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule